// File: doc/BRIEF.md
# Paired-Sample DMA Request Scanner

The block samples seven DMA request lines through an external 4-to-1 multiplexer. It reads two lines on every cycle of the timebase clock. It drives the multiplexer select, keeps the last sampled level of each request in a pending register indexed by channel number, and offers the pending requests that the channel mask allows to an external arbitration stage. Channel numbers run 0 to 7. Channel 4 is the cascade channel: it is never sampled, never pending and never offered.

When the arbiter returns a grant for an offered channel, the block stops scanning and holds the select on the pair that contains that channel. It drives the channel number on a 3-bit acknowledge code. One cycle later it pulls an active-low decoder enable, so an external 3-to-8 decoder can rebuild the acknowledge line. The requester normally ends the transfer by dropping its request. The block sees this while it keeps sampling the held pair. It then releases the enable, waits one cycle, and resumes scanning at the pair where it stopped.

Top module: `reqscan`

## Requirements
- R1: While reset is held, and in the first cycle after it, mux_sel is 0, ack_code is 0, ack_en_n is 1 and offer is all zeros.
- R2: While no grant is accepted, mux_sel steps 0,1,2,3,0,... by one on every clock, so all seven requests are read within four cycles.
- R3: On each clock the two multiplexer inputs are latched as the pending level of the pair's channels. Select 0 reads channels 0 (input a) and 1 (input b). Select 1 reads 2 and 3. Select 2 reads 5 and 6. Select 3 reads 7 on input a, and input b is ignored. Bit 4 of offer is always 0.
- R4: While scanning, offer equals the pending bits ANDed with chan_mask. A masked channel keeps its pending bit and is offered as soon as its mask bit is set. A grant for a channel that is not offered is ignored.
- R5: When grant_vld is high on a clock edge and grant_ch is offered, then after that edge mux_sel holds the pair of grant_ch, ack_code equals grant_ch and ack_en_n is still 1.
- R6: ack_en_n goes low exactly one cycle after the acknowledge code is loaded.
- R7: While acknowledging, the held channel's request is sampled on every clock. When a sample is 0, ack_en_n returns to 1 after that edge. One cycle later scanning restarts at the held pair, and mux_sel is unchanged through these steps.
- R8: ack_code changes only in a cycle where ack_en_n is 1 and was 1 in the cycle before.
- R9: From grant acceptance until scanning restarts, offer is all zeros and grants have no effect.
- R10: While the scan is frozen, the pending bits of channels outside the held pair keep their values, and the held pair keeps being refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one pair sampled per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_sel | output | 2 | Select lines of the external request multiplexer |
| mux_in_a | input | 1 | Multiplexer output carrying the lower channel of the pair |
| mux_in_b | input | 1 | Multiplexer output carrying the upper channel of the pair |
| chan_mask | input | 8 | Per-channel enable, indexed by channel number |
| offer | output | 8 | Pending and enabled requests presented to the arbiter |
| grant_vld | input | 1 | Arbiter grant strobe |
| grant_ch | input | 3 | Channel number being granted |
| ack_code | output | 3 | Encoded acknowledge channel for the external decoder |
| ack_en_n | output | 1 | Active-low enable of the external decoder |

## Verification
A wrong scan pointer shows on mux_sel in the same cycle, and on offer once the misplaced sample has been latched, one cycle later. A wrongly latched or lost pending bit appears on offer in the cycle after the sample, while scanning continues. During a freeze it stays hidden until the first scan cycle after the release. A state machine that misses the release, or restarts at the wrong pair, keeps ack_en_n low or moves mux_sel within one or two cycles of the request dropping.

// File: rtl/reqscan_pkg.sv
package reqscan_pkg;

   typedef enum logic [1:0] {
      SQ_SCAN  = 2'd0,
      SQ_SETUP = 2'd1,
      SQ_HOLD  = 2'd2,
      SQ_DROP  = 2'd3
   } seq_state_t;

   // position of a channel in the scan order, cascade channel skipped
   function automatic int slot_of(input int ch, input int cascade);
      return (ch < cascade) ? ch : ch - 1;
   endfunction

   function automatic int pair_of(input int ch, input int cascade);
      return slot_of(ch, cascade) / 2;
   endfunction

   // 0: multiplexer input a, 1: input b
   function automatic int side_of(input int ch, input int cascade);
      return slot_of(ch, cascade) % 2;
   endfunction

endpackage

// File: rtl/reqscan_pending.sv
module reqscan_pending
   import reqscan_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int SEL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic              smp_a,
   input  logic              smp_b,
   output logic [NUM_CH-1:0] pend
);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      if (ch == CASCADE_CH) begin : g_cascade
         assign pend[ch] = 1'b0;
      end else begin : g_req
         localparam int          PAIR = pair_of(ch, CASCADE_CH);
         localparam int          SIDE = side_of(ch, CASCADE_CH);
         localparam [SEL_W-1:0]  PSEL = SEL_W'(PAIR);
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (sel == PSEL)
               bit_q <= (SIDE == 1) ? smp_b : smp_a;
         end
         assign pend[ch] = bit_q;
      end
   end

endmodule

// File: rtl/reqscan_seq.sv
module reqscan_seq
   import reqscan_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int NUM_PAIRS  = 4,
   parameter int SEL_W      = 2,
   parameter int CODE_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] avail,
   input  logic              grant_vld,
   input  logic [CODE_W-1:0] grant_ch,
   input  logic [CODE_W-1:0] held_ch,
   input  logic              smp_a,
   input  logic              smp_b,
   output logic [SEL_W-1:0]  sel,
   output logic              scanning,
   output logic              load_code,
   output logic              en_on,
   output logic              en_off
);

   localparam [SEL_W-1:0] LAST_PAIR = SEL_W'(NUM_PAIRS - 1);

   seq_state_t st_q;
   logic [SEL_W-1:0] sel_q;
   logic accept;
   logic held_side;
   logic held_level;
   logic [SEL_W-1:0] grant_pair;

   // pair and side lookup over all channel numbers
   always_comb begin
      grant_pair = '0;
      held_side  = 1'b0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (ch != CASCADE_CH) begin
            if (grant_ch == CODE_W'(ch))
               grant_pair = SEL_W'(pair_of(ch, CASCADE_CH));
            if (held_ch == CODE_W'(ch))
               held_side = (side_of(ch, CASCADE_CH) == 1);
         end
      end
   end

   assign scanning   = (st_q == SQ_SCAN);
   assign accept     = scanning && grant_vld && avail[grant_ch];
   assign held_level = held_side ? smp_b : smp_a;
   assign load_code  = accept;
   assign en_on      = (st_q == SQ_SETUP);
   assign en_off     = (st_q == SQ_HOLD) && !held_level;
   assign sel        = sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_SCAN;
         sel_q <= '0;
      end else begin
         unique case (st_q)
            SQ_SCAN: begin
               if (accept) begin
                  st_q  <= SQ_SETUP;
                  sel_q <= grant_pair;
               end else begin
                  sel_q <= (sel_q == LAST_PAIR) ? '0 : sel_q + 1'b1;
               end
            end
            SQ_SETUP: st_q <= SQ_HOLD;
            SQ_HOLD:  if (!held_level) st_q <= SQ_DROP;
            SQ_DROP:  st_q <= SQ_SCAN;
            default:  st_q <= SQ_SCAN;
         endcase
      end
   end

endmodule

// File: rtl/reqscan_ackenc.sv
module reqscan_ackenc #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_code,
   input  logic [CODE_W-1:0] new_code,
   input  logic              en_on,
   input  logic              en_off,
   output logic [CODE_W-1:0] code,
   output logic              en_n
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= '0;
         en_n <= 1'b1;
      end else begin
         if (load_code) code <= new_code;
         if (en_on)       en_n <= 1'b0;
         else if (en_off) en_n <= 1'b1;
      end
   end

endmodule

// File: rtl/reqscan.sv
module reqscan
   import reqscan_pkg::*;
#(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int CODE_W     = $clog2(NUM_CH),
   parameter int SEL_W      = $clog2((NUM_CH + 0) / 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [SEL_W-1:0]  mux_sel,
   input  logic              mux_in_a,
   input  logic              mux_in_b,
   input  logic [NUM_CH-1:0] chan_mask,
   output logic [NUM_CH-1:0] offer,
   input  logic              grant_vld,
   input  logic [CODE_W-1:0] grant_ch,
   output logic [CODE_W-1:0] ack_code,
   output logic              ack_en_n
);

   localparam int NUM_REQ   = NUM_CH - 1;
   localparam int NUM_PAIRS = (NUM_REQ + 1) / 2;

   if (NUM_CH != (1 << CODE_W)) begin : g_bad_code
      $error("NUM_CH must equal 2**CODE_W");
   end
   if (NUM_PAIRS > (1 << SEL_W)) begin : g_bad_sel
      $error("SEL_W too narrow for the pair count");
   end
   if (CASCADE_CH < 0 || CASCADE_CH >= NUM_CH) begin : g_bad_casc
      $error("CASCADE_CH out of range");
   end

   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] avail;
   logic scanning, load_code, en_on, en_off;

   reqscan_pending #(
      .NUM_CH(NUM_CH), .CASCADE_CH(CASCADE_CH), .SEL_W(SEL_W)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .sel(mux_sel),
      .smp_a(mux_in_a), .smp_b(mux_in_b), .pend(pend)
   );

   assign avail = pend & chan_mask;
   assign offer = scanning ? avail : '0;

   reqscan_seq #(
      .NUM_CH(NUM_CH), .CASCADE_CH(CASCADE_CH), .NUM_PAIRS(NUM_PAIRS),
      .SEL_W(SEL_W), .CODE_W(CODE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .avail(avail),
      .grant_vld(grant_vld), .grant_ch(grant_ch), .held_ch(ack_code),
      .smp_a(mux_in_a), .smp_b(mux_in_b), .sel(mux_sel),
      .scanning(scanning), .load_code(load_code),
      .en_on(en_on), .en_off(en_off)
   );

   reqscan_ackenc #(.CODE_W(CODE_W)) u_ack (
      .clk(clk), .rst_n(rst_n), .load_code(load_code), .new_code(grant_ch),
      .en_on(en_on), .en_off(en_off), .code(ack_code), .en_n(ack_en_n)
   );

endmodule

// File: rtl/reqscan_chk.sv
module reqscan_chk #(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int CODE_W     = 3,
   parameter int SEL_W      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  mux_sel,
   input logic [NUM_CH-1:0] offer,
   input logic [CODE_W-1:0] ack_code,
   input logic              ack_en_n
);

   // R3
   cascade_never_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      offer[CASCADE_CH] == 1'b0);

   // R9
   no_offer_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_en_n |-> offer == '0);

   // R6
   code_settled_at_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_en_n) |-> $stable(ack_code));

   // R8
   code_moves_only_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ack_code) |-> (ack_en_n && $past(ack_en_n)));

   // R5
   sel_frozen_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_en_n |=> $stable(mux_sel));

   // R7
   resume_at_held_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_en_n) |=> $stable(mux_sel));

endmodule

bind reqscan reqscan_chk #(
   .NUM_CH(NUM_CH), .CASCADE_CH(CASCADE_CH), .CODE_W(CODE_W), .SEL_W(SEL_W)
) u_reqscan_chk (
   .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .offer(offer),
   .ack_code(ack_code), .ack_en_n(ack_en_n)
);

// File: tb/test_reqscan.sv
module test_reqscan;

   localparam int CLK_PERIOD = 70;
   localparam int N_CYC      = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mux_sel;
   logic       mux_in_a, mux_in_b;
   logic [7:0] chan_mask = 8'hFF;
   logic [7:0] offer;
   logic       grant_vld = 1'b0;
   logic [2:0] grant_ch = 3'd0;
   logic [2:0] ack_code;
   logic       ack_en_n;

   logic [7:0] req = 8'h00;
   logic       spare = 1'b1;   // unused multiplexer input, held high

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // external 4-to-1 multiplexer pair
   always_comb begin
      case (mux_sel)
         2'd0: begin mux_in_a = req[0]; mux_in_b = req[1]; end
         2'd1: begin mux_in_a = req[2]; mux_in_b = req[3]; end
         2'd2: begin mux_in_a = req[5]; mux_in_b = req[6]; end
         default: begin mux_in_a = req[7]; mux_in_b = spare; end
      endcase
   end

   reqscan i_reqscan (
      .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel),
      .mux_in_a(mux_in_a), .mux_in_b(mux_in_b), .chan_mask(chan_mask),
      .offer(offer), .grant_vld(grant_vld), .grant_ch(grant_ch),
      .ack_code(ack_code), .ack_en_n(ack_en_n)
   );

   // reference model state: 0 scan, 1 code set, 2 acknowledging, 3 releasing
   int       m_st = 0;
   int       m_ptr = 0;
   bit [7:0] m_pend = 8'h00;
   int       m_code = 0;
   bit       m_en_n = 1'b1;

   function automatic int pair_idx(input int ch);
      if (ch <= 1) return 0;
      if (ch <= 3) return 1;
      if (ch <= 6) return 2;
      return 3;
   endfunction

   function automatic bit [7:0] exp_offer();
      return (m_st == 0) ? (m_pend & chan_mask & 8'hEF) : 8'h00;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R2/R5/R7 mux_sel", int'(mux_sel), m_ptr);
      check("R5/R8 ack_code", int'(ack_code), m_code);
      check("R6/R7 ack_en_n", int'(ack_en_n), int'(m_en_n));
      check("R3/R4/R9/R10 offer", int'(offer), int'(exp_offer()));
   endtask

   // advance the model by one clock using the inputs now applied
   task automatic model_step();
      bit [7:0] av;
      bit acc;
      av  = m_pend & chan_mask & 8'hEF;
      acc = (m_st == 0) && grant_vld && av[grant_ch];
      case (m_ptr)
         0: begin m_pend[0] = req[0]; m_pend[1] = req[1]; end
         1: begin m_pend[2] = req[2]; m_pend[3] = req[3]; end
         2: begin m_pend[5] = req[5]; m_pend[6] = req[6]; end
         default: m_pend[7] = req[7];
      endcase
      case (m_st)
         0: if (acc) begin
               m_st = 1; m_code = int'(grant_ch); m_ptr = pair_idx(int'(grant_ch));
            end else m_ptr = (m_ptr + 1) % 4;
         1: begin m_st = 2; m_en_n = 1'b0; end
         2: if (!req[m_code]) begin m_st = 3; m_en_n = 1'b1; end
         default: m_st = 0;
      endcase
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 mux_sel", int'(mux_sel), 0);
      check("R1 ack_en_n", int'(ack_en_n), 1);
      check("R1 ack_code", int'(ack_code), 0);
      check("R1 offer", int'(offer), 0);
      rst_n = 1'b1;
      model_step();
      for (int i = 0; i < N_CYC; i++) begin
         @(negedge clk);
         compare_all();
         // request lines: occasional toggles, channel 4 driven but unused
         for (int b = 0; b < 8; b++)
            if ($urandom % 8 == 0) req[b] = ~req[b];
         // R4: disable channels 2 and 5 for the middle phase
         chan_mask = (i >= 1000 && i < 2000) ? 8'hDB : 8'hFF;
         // arbiter stand-in
         grant_vld = ($urandom % 3) != 0;
         grant_ch  = 3'($urandom % 8);
         if (($urandom % 4) != 0) begin
            bit [7:0] ofr;
            ofr = exp_offer();
            for (int c = 7; c >= 0; c--)
               if (ofr[c]) grant_ch = 3'(c);
         end
         model_step();
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (N_CYC + 200) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired, actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule